// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 32-bit instruction word into the register indices, the function field, an extended immediate and a set of control strobes. A single-cycle or pipelined core uses these outputs to steer its execute stage, its register file and its data memory. The decoder has no state and no clock. Every output follows the instruction word combinationally.

The word has three layouts, and all three share the same upper part. A 7-bit opcode sits at bits [31:25] and the destination index sits at [24:20]. In the register-register layout the first source is at [19:15], the second source at [14:10] and a 10-bit function selector at [9:0]. In the immediate layout the first source is at [19:15] and a 15-bit constant at [14:0]. In the jump layout a 20-bit field fills [19:0]. Opcode 0x01 selects the register-register class, and the function selector picks the operation within it. The opcode map also includes stack push and pop through r2, moves to and from the 4-bit status register, and a halt request.

The decoder flags any opcode outside the map, and any register-register selector outside 1 to 15, as illegal. An illegal word turns off every strobe. The datapath, the memory and the assembler pseudo-operations lie outside this block.

Top module: `instrDecoder`

## Requirements
- R1: `rdIdx` is bits [24:20], `rs1Idx` is bits [19:15] and `functCode` is bits [9:0], raw, for every word. `rs2Idx` is bits [14:10] for opcode 0x01, bits [24:20] for the two store opcodes, and 0 otherwise.
- R2: Opcode 0x01 with a function selector f in 1..15 gives `aluOp` = f-1, `srcBImm`=0 and `regWrEn`=1. The `aluOp` codes are 0 add, 1 sub, 2 mul, 3 div, 4 rem, 5 multiply-accumulate, 6 and, 7 or, 8 xor, 9 shl, 10 shr logical, 11 shr arithmetic, 12 bit-field extract, 13 byte swap, 14 count leading zeros and 15 pass-B.
- R3: Opcodes 0x08..0x11 give `aluOp` 0,2,3,4,6,7,8,9,10,11 in that order, with `srcBImm`=1, `regWrEn`=1 and `immValue` = bits [14:0] sign-extended from bit 14.
- R4: Opcode 0x12 gives `aluOp`=15, `srcBImm`=1, `regWrEn`=1 and `immValue` = bits [19:0] shifted left by 12.
- R5: The memory opcodes all give `aluOp`=0, `srcBImm`=1 and `immValue` = bits [14:0] sign-extended. For 0x18 (word), 0x1A (byte, signed) and 0x1B (byte, unsigned), `memRead`=1 and `regWrEn`=1. For 0x19 (word store) and 0x1C (byte store), `memWrite`=1 and `regWrEn`=0. `memByte` marks 0x1A, 0x1B and 0x1C, and `loadSigned` marks only 0x1A.
- R6: `branchKind` takes these codes: 1 for 0x30, 2 for 0x31, 3 for 0x32, 4..9 for 0x20..0x25, and 0 otherwise. For the jump and branch opcodes, `immValue` = bits [19:0] sign-extended. For 0x32, `immValue`=0. Only 0x31 writes `rdIdx` (the link register).
- R7: 0x40 gives `pushOp`=1, `memWrite`=1, `aluOp`=1, `srcBImm`=1 and `immValue`=4 (the new r2 value is r2-4). 0x41 gives `popOp`=1, `memRead`=1, `regWrEn`=1, `aluOp`=0, `srcBImm`=1 and `immValue`=4 (the read is from the current r2, which then goes up by 4).
- R8: 0x42 gives `srToReg`=1 and `regWrEn`=1. 0x43 gives `regToSr`=1. 0x44 gives `haltReq`=1 and writes nothing.
- R9: `regWrEn` is 0 whenever bits [24:20] are 0.
- R10: Any other opcode, or opcode 0x01 with a selector of 0 or above 15, gives `illegalInstr`=1. In that case every strobe, `aluOp`, `branchKind`, `rs2Idx` and `immValue` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| rdIdx | output | 5 | Destination register index |
| rs1Idx | output | 5 | First source register index |
| rs2Idx | output | 5 | Second source or store-data register index |
| functCode | output | 10 | Raw function selector field |
| immValue | output | 32 | Extended or shifted immediate |
| aluOp | output | 4 | ALU operation code |
| srcBImm | output | 1 | ALU B operand comes from immValue |
| regWrEn | output | 1 | Write result to rdIdx |
| memRead | output | 1 | Data memory read |
| memWrite | output | 1 | Data memory write |
| memByte | output | 1 | Memory access is one byte |
| loadSigned | output | 1 | Byte load is sign-extended |
| branchKind | output | 4 | Jump or branch condition code |
| pushOp | output | 1 | Stack push through r2 |
| popOp | output | 1 | Stack pop through r2 |
| srToReg | output | 1 | Copy status register to rdIdx |
| regToSr | output | 1 | Copy low bits of rs1 to status register |
| haltReq | output | 1 | Halt request |
| illegalInstr | output | 1 | Word not in the decode map |

## Verification
The bench targets the sign bit at position 14 of the short constant and at position 19 of the jump field. A decoder that zero-extends either one produces wrong negative offsets and negative add constants. It drives function selectors 0 and 16 and up, and opcodes just outside each group (0x13, 0x1D, 0x26, 0x45). A decoder with loose range checks would accept these words and fire write strobes. It uses destination index 0 with every writing opcode, where a missing guard would corrupt r0. It uses stores, where taking the data index from [14:10] instead of [24:20] sends the wrong register to memory.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int OPC_W = 7;

  localparam logic [OPC_W-1:0] OP_RTYPE = 7'h01;
  localparam logic [OPC_W-1:0] OP_ADDI  = 7'h08;
  localparam logic [OPC_W-1:0] OP_MULI  = 7'h09;
  localparam logic [OPC_W-1:0] OP_DIVI  = 7'h0A;
  localparam logic [OPC_W-1:0] OP_REMI  = 7'h0B;
  localparam logic [OPC_W-1:0] OP_ANDI  = 7'h0C;
  localparam logic [OPC_W-1:0] OP_ORI   = 7'h0D;
  localparam logic [OPC_W-1:0] OP_XORI  = 7'h0E;
  localparam logic [OPC_W-1:0] OP_SHLI  = 7'h0F;
  localparam logic [OPC_W-1:0] OP_SHRLI = 7'h10;
  localparam logic [OPC_W-1:0] OP_SHRAI = 7'h11;
  localparam logic [OPC_W-1:0] OP_UPPER = 7'h12;
  localparam logic [OPC_W-1:0] OP_LDW   = 7'h18;
  localparam logic [OPC_W-1:0] OP_STW   = 7'h19;
  localparam logic [OPC_W-1:0] OP_LDBS  = 7'h1A;
  localparam logic [OPC_W-1:0] OP_LDBU  = 7'h1B;
  localparam logic [OPC_W-1:0] OP_STB   = 7'h1C;
  localparam logic [OPC_W-1:0] OP_BEQ   = 7'h20;
  localparam logic [OPC_W-1:0] OP_BNE   = 7'h21;
  localparam logic [OPC_W-1:0] OP_BLT   = 7'h22;
  localparam logic [OPC_W-1:0] OP_BGE   = 7'h23;
  localparam logic [OPC_W-1:0] OP_BHI   = 7'h24;
  localparam logic [OPC_W-1:0] OP_BLS   = 7'h25;
  localparam logic [OPC_W-1:0] OP_JUMP  = 7'h30;
  localparam logic [OPC_W-1:0] OP_LINK  = 7'h31;
  localparam logic [OPC_W-1:0] OP_RETN  = 7'h32;
  localparam logic [OPC_W-1:0] OP_PUSH  = 7'h40;
  localparam logic [OPC_W-1:0] OP_POP   = 7'h41;
  localparam logic [OPC_W-1:0] OP_SRRD  = 7'h42;
  localparam logic [OPC_W-1:0] OP_SRWR  = 7'h43;
  localparam logic [OPC_W-1:0] OP_HALT  = 7'h44;

  localparam int MAX_FUNCT = 15;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_REM, ALU_MAC, ALU_AND, ALU_OR,
    ALU_XOR, ALU_SHL, ALU_SHRL, ALU_SHRA, ALU_FIELD, ALU_BSWAP, ALU_CLZ, ALU_PASSB
  } aluOp_e;

  typedef enum logic [3:0] {
    BR_NONE, BR_JUMP, BR_LINK, BR_RETN, BR_EQ, BR_NE, BR_LT, BR_GE, BR_HI, BR_LS
  } brKind_e;

  typedef enum logic [2:0] {
    IMM_ZERO, IMM_SHORT, IMM_UPPER, IMM_JOFF, IMM_STEP
  } immSel_e;

  typedef enum logic [1:0] {
    RS2_ZERO, RS2_RFIELD, RS2_DFIELD
  } rs2Sel_e;

  typedef struct packed {
    aluOp_e  aluOp;
    logic    srcBImm;
    logic    regWrEn;
    logic    memRead;
    logic    memWrite;
    logic    memByte;
    logic    loadSigned;
    brKind_e branchKind;
    logic    pushOp;
    logic    popOp;
    logic    srToReg;
    logic    regToSr;
    logic    haltReq;
    logic    illegal;
    immSel_e immSel;
    rs2Sel_e rs2Sel;
  } ctrl_t;

endpackage

// File: rtl/idecFields.sv
module idecFields
  import idec_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int REG_AW      = 5,
  parameter int UPPER_SHIFT = 12,
  parameter int STACK_STEP  = 4
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  immSel_e            immSel,
  input  rs2Sel_e            rs2Sel,
  output logic [OPC_W-1:0]   opcode,
  output logic [REG_AW-1:0]  rdIdx,
  output logic [REG_AW-1:0]  rs1Idx,
  output logic [REG_AW-1:0]  rs2Idx,
  output logic [INSTR_W-OPC_W-3*REG_AW-1:0] functCode,
  output logic [INSTR_W-1:0] immValue
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - REG_AW;
  localparam int RS1_LSB = RD_LSB - REG_AW;
  localparam int RS2_LSB = RS1_LSB - REG_AW;
  localparam int SHORT_W = RS1_LSB;
  localparam int JOFF_W  = RD_LSB;

  logic [SHORT_W-1:0] shortField;
  logic [JOFF_W-1:0]  jumpField;
  logic [INSTR_W-1:0] shortExt;
  logic [INSTR_W-1:0] jumpExt;
  logic [INSTR_W-1:0] upperVal;

  assign opcode     = instrWord[INSTR_W-1:OPC_LSB];
  assign rdIdx      = instrWord[RD_LSB +: REG_AW];
  assign rs1Idx     = instrWord[RS1_LSB +: REG_AW];
  assign functCode  = instrWord[RS2_LSB-1:0];
  assign shortField = instrWord[SHORT_W-1:0];
  assign jumpField  = instrWord[JOFF_W-1:0];

  assign shortExt = {{(INSTR_W-SHORT_W){shortField[SHORT_W-1]}}, shortField};
  assign jumpExt  = {{(INSTR_W-JOFF_W){jumpField[JOFF_W-1]}}, jumpField};
  assign upperVal = {{(INSTR_W-JOFF_W){1'b0}}, jumpField} << UPPER_SHIFT;

  always_comb begin
    unique case (immSel)
      IMM_SHORT: immValue = shortExt;
      IMM_UPPER: immValue = upperVal;
      IMM_JOFF:  immValue = jumpExt;
      IMM_STEP:  immValue = INSTR_W'(STACK_STEP);
      default:   immValue = '0;
    endcase
  end

  always_comb begin
    unique case (rs2Sel)
      RS2_RFIELD: rs2Idx = instrWord[RS2_LSB +: REG_AW];
      RS2_DFIELD: rs2Idx = instrWord[RD_LSB +: REG_AW];
      default:    rs2Idx = '0;
    endcase
  end

  // R4: an upper-constant result never carries low bits
  always_comb begin
    if (immSel == IMM_UPPER)
      assert_upper_clean_R4: assert (immValue[UPPER_SHIFT-1:0] == '0);
  end

endmodule

// File: rtl/idecControl.sv
module idecControl
  import idec_pkg::*;
#(
  parameter int FUNCT_W = 10
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] functCode,
  output ctrl_t              ctrl
);

  logic functOk;
  assign functOk = (functCode != '0) && (functCode <= FUNCT_W'(MAX_FUNCT));

  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        if (functOk) begin
          ctrl.aluOp   = aluOp_e'(4'(functCode - FUNCT_W'(1)));
          ctrl.regWrEn = 1'b1;
          ctrl.rs2Sel  = RS2_RFIELD;
        end else begin
          ctrl.illegal = 1'b1;
        end
      end
      OP_ADDI, OP_MULI, OP_DIVI, OP_REMI, OP_ANDI,
      OP_ORI, OP_XORI, OP_SHLI, OP_SHRLI, OP_SHRAI: begin
        ctrl.srcBImm = 1'b1;
        ctrl.regWrEn = 1'b1;
        ctrl.immSel  = IMM_SHORT;
        unique case (opcode)
          OP_ADDI:  ctrl.aluOp = ALU_ADD;
          OP_MULI:  ctrl.aluOp = ALU_MUL;
          OP_DIVI:  ctrl.aluOp = ALU_DIV;
          OP_REMI:  ctrl.aluOp = ALU_REM;
          OP_ANDI:  ctrl.aluOp = ALU_AND;
          OP_ORI:   ctrl.aluOp = ALU_OR;
          OP_XORI:  ctrl.aluOp = ALU_XOR;
          OP_SHLI:  ctrl.aluOp = ALU_SHL;
          OP_SHRLI: ctrl.aluOp = ALU_SHRL;
          default:  ctrl.aluOp = ALU_SHRA;
        endcase
      end
      OP_UPPER: begin
        ctrl.aluOp   = ALU_PASSB;
        ctrl.srcBImm = 1'b1;
        ctrl.regWrEn = 1'b1;
        ctrl.immSel  = IMM_UPPER;
      end
      OP_LDW, OP_LDBS, OP_LDBU: begin
        ctrl.srcBImm    = 1'b1;
        ctrl.regWrEn    = 1'b1;
        ctrl.memRead    = 1'b1;
        ctrl.memByte    = (opcode != OP_LDW);
        ctrl.loadSigned = (opcode == OP_LDBS);
        ctrl.immSel     = IMM_SHORT;
      end
      OP_STW, OP_STB: begin
        ctrl.srcBImm  = 1'b1;
        ctrl.memWrite = 1'b1;
        ctrl.memByte  = (opcode == OP_STB);
        ctrl.immSel   = IMM_SHORT;
        ctrl.rs2Sel   = RS2_DFIELD;
      end
      OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BHI, OP_BLS: begin
        ctrl.immSel = IMM_JOFF;
        unique case (opcode)
          OP_BEQ:  ctrl.branchKind = BR_EQ;
          OP_BNE:  ctrl.branchKind = BR_NE;
          OP_BLT:  ctrl.branchKind = BR_LT;
          OP_BGE:  ctrl.branchKind = BR_GE;
          OP_BHI:  ctrl.branchKind = BR_HI;
          default: ctrl.branchKind = BR_LS;
        endcase
      end
      OP_JUMP: begin
        ctrl.branchKind = BR_JUMP;
        ctrl.immSel     = IMM_JOFF;
      end
      OP_LINK: begin
        ctrl.branchKind = BR_LINK;
        ctrl.immSel     = IMM_JOFF;
        ctrl.regWrEn    = 1'b1;
      end
      OP_RETN: ctrl.branchKind = BR_RETN;
      OP_PUSH: begin
        ctrl.pushOp   = 1'b1;
        ctrl.memWrite = 1'b1;
        ctrl.aluOp    = ALU_SUB;
        ctrl.srcBImm  = 1'b1;
        ctrl.immSel   = IMM_STEP;
      end
      OP_POP: begin
        ctrl.popOp   = 1'b1;
        ctrl.memRead = 1'b1;
        ctrl.regWrEn = 1'b1;
        ctrl.aluOp   = ALU_ADD;
        ctrl.srcBImm = 1'b1;
        ctrl.immSel  = IMM_STEP;
      end
      OP_SRRD: begin
        ctrl.srToReg = 1'b1;
        ctrl.regWrEn = 1'b1;
      end
      OP_SRWR: ctrl.regToSr = 1'b1;
      OP_HALT: ctrl.haltReq = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

  always_comb begin
    // R5: a memory cycle is either a read or a write
    assert_mem_excl_R5: assert (!(ctrl.memRead && ctrl.memWrite));
    // R7/R8: at most one special operation per word
    assert_special_single_R7: assert ($onehot0({ctrl.pushOp, ctrl.popOp, ctrl.srToReg,
                                                ctrl.regToSr, ctrl.haltReq}));
    // R10: an illegal word drives no strobe
    if (ctrl.illegal)
      assert_illegal_quiet_R10: assert (!ctrl.regWrEn && !ctrl.memRead && !ctrl.memWrite &&
                                        ctrl.branchKind == BR_NONE && !ctrl.pushOp &&
                                        !ctrl.popOp && !ctrl.regToSr && !ctrl.haltReq);
  end

endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import idec_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int REG_AW      = 5,
  parameter int UPPER_SHIFT = 12,
  parameter int STACK_STEP  = 4,
  localparam int FUNCT_W    = INSTR_W - OPC_W - 3 * REG_AW
) (
  input  logic [INSTR_W-1:0] instrWord,
  output logic [REG_AW-1:0]  rdIdx,
  output logic [REG_AW-1:0]  rs1Idx,
  output logic [REG_AW-1:0]  rs2Idx,
  output logic [FUNCT_W-1:0] functCode,
  output logic [INSTR_W-1:0] immValue,
  output logic [3:0]         aluOp,
  output logic               srcBImm,
  output logic               regWrEn,
  output logic               memRead,
  output logic               memWrite,
  output logic               memByte,
  output logic               loadSigned,
  output logic [3:0]         branchKind,
  output logic               pushOp,
  output logic               popOp,
  output logic               srToReg,
  output logic               regToSr,
  output logic               haltReq,
  output logic               illegalInstr
);

  logic [OPC_W-1:0] opcode;
  ctrl_t            ctrl;

  idecFields #(
    .INSTR_W    (INSTR_W),
    .REG_AW     (REG_AW),
    .UPPER_SHIFT(UPPER_SHIFT),
    .STACK_STEP (STACK_STEP)
  ) fields_i (
    .instrWord(instrWord),
    .immSel   (ctrl.immSel),
    .rs2Sel   (ctrl.rs2Sel),
    .opcode   (opcode),
    .rdIdx    (rdIdx),
    .rs1Idx   (rs1Idx),
    .rs2Idx   (rs2Idx),
    .functCode(functCode),
    .immValue (immValue)
  );

  idecControl #(
    .FUNCT_W(FUNCT_W)
  ) control_i (
    .opcode   (opcode),
    .functCode(functCode),
    .ctrl     (ctrl)
  );

  assign aluOp        = ctrl.aluOp;
  assign srcBImm      = ctrl.srcBImm;
  assign regWrEn      = ctrl.regWrEn && (rdIdx != '0);
  assign memRead      = ctrl.memRead;
  assign memWrite     = ctrl.memWrite;
  assign memByte      = ctrl.memByte;
  assign loadSigned   = ctrl.loadSigned;
  assign branchKind   = ctrl.branchKind;
  assign pushOp       = ctrl.pushOp;
  assign popOp        = ctrl.popOp;
  assign srToReg      = ctrl.srToReg;
  assign regToSr      = ctrl.regToSr;
  assign haltReq      = ctrl.haltReq;
  assign illegalInstr = ctrl.illegal;

  always_comb begin
    // R9: a zero destination field never yields a register write
    if (instrWord[INSTR_W-OPC_W-1 -: REG_AW] == '0)
      assert_r0_nowrite_R9: assert (!regWrEn);
    // R5: stores and pushes never write the register file
    if (memWrite)
      assert_store_nowb_R5: assert (!regWrEn);
    // R6: only the linking jump writes among control transfers
    if (branchKind != 4'd0 && branchKind != 4'd2)
      assert_branch_nowb_R6: assert (!regWrEn);
  end

endmodule

// File: tb/instrDecoder_tb_top.sv
module instrDecoder_tb_top;

  typedef struct packed {
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [9:0]  funct;
    logic [31:0] imm;
    logic [3:0]  alu;
    logic        srcB;
    logic        regWr;
    logic        memRd;
    logic        memWr;
    logic        memB;
    logic        ldSgn;
    logic [3:0]  br;
    logic        push;
    logic        pop;
    logic        srTo;
    logic        toSr;
    logic        halt;
    logic        ill;
  } dec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instrWord = '0;
  logic [4:0]  rdIdx, rs1Idx, rs2Idx;
  logic [9:0]  functCode;
  logic [31:0] immValue;
  logic [3:0]  aluOp, branchKind;
  logic srcBImm, regWrEn, memRead, memWrite, memByte, loadSigned;
  logic pushOp, popOp, srToReg, regToSr, haltReq, illegalInstr;

  instrDecoder dut_i (
    .instrWord(instrWord), .rdIdx(rdIdx), .rs1Idx(rs1Idx), .rs2Idx(rs2Idx),
    .functCode(functCode), .immValue(immValue), .aluOp(aluOp), .srcBImm(srcBImm),
    .regWrEn(regWrEn), .memRead(memRead), .memWrite(memWrite), .memByte(memByte),
    .loadSigned(loadSigned), .branchKind(branchKind), .pushOp(pushOp), .popOp(popOp),
    .srToReg(srToReg), .regToSr(regToSr), .haltReq(haltReq), .illegalInstr(illegalInstr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] sx15(input logic [31:0] w);
    return {{17{w[14]}}, w[14:0]};
  endfunction

  function automatic logic [31:0] sx20(input logic [31:0] w);
    return {{12{w[19]}}, w[19:0]};
  endfunction

  function automatic dec_t expectOf(input logic [31:0] w);
    dec_t e;
    logic [6:0] op;
    int f;
    e = '0;
    op = w[31:25];
    e.rd = w[24:20];
    e.rs1 = w[19:15];
    e.funct = w[9:0];
    f = int'(w[9:0]);
    case (op)
      7'h01: if (f >= 1 && f <= 15) begin
               e.alu = 4'(f - 1); e.regWr = 1; e.rs2 = w[14:10];
             end else e.ill = 1;
      7'h08: begin e.alu = 0;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h09: begin e.alu = 2;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h0A: begin e.alu = 3;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h0B: begin e.alu = 4;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h0C: begin e.alu = 6;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h0D: begin e.alu = 7;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h0E: begin e.alu = 8;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h0F: begin e.alu = 9;  e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h10: begin e.alu = 10; e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h11: begin e.alu = 11; e.srcB = 1; e.regWr = 1; e.imm = sx15(w); end
      7'h12: begin e.alu = 15; e.srcB = 1; e.regWr = 1; e.imm = {w[19:0], 12'h000}; end
      7'h18: begin e.srcB = 1; e.regWr = 1; e.memRd = 1; e.imm = sx15(w); end
      7'h1A: begin e.srcB = 1; e.regWr = 1; e.memRd = 1; e.memB = 1; e.ldSgn = 1; e.imm = sx15(w); end
      7'h1B: begin e.srcB = 1; e.regWr = 1; e.memRd = 1; e.memB = 1; e.imm = sx15(w); end
      7'h19: begin e.srcB = 1; e.memWr = 1; e.imm = sx15(w); e.rs2 = w[24:20]; end
      7'h1C: begin e.srcB = 1; e.memWr = 1; e.memB = 1; e.imm = sx15(w); e.rs2 = w[24:20]; end
      7'h20, 7'h21, 7'h22, 7'h23, 7'h24, 7'h25:
             begin e.br = 4'(int'(op) - 32 + 4); e.imm = sx20(w); end
      7'h30: begin e.br = 1; e.imm = sx20(w); end
      7'h31: begin e.br = 2; e.imm = sx20(w); e.regWr = 1; end
      7'h32: e.br = 3;
      7'h40: begin e.push = 1; e.memWr = 1; e.alu = 1; e.srcB = 1; e.imm = 32'd4; end
      7'h41: begin e.pop = 1; e.memRd = 1; e.regWr = 1; e.srcB = 1; e.imm = 32'd4; end
      7'h42: begin e.srTo = 1; e.regWr = 1; end
      7'h43: e.toSr = 1;
      7'h44: e.halt = 1;
      default: e.ill = 1;
    endcase
    if (e.rd == 5'd0) e.regWr = 0;
    return e;
  endfunction

  function automatic string reqOf(input logic [31:0] w);
    logic [6:0] op;
    op = w[31:25];
    if (w[24:20] == 5'd0) return "R9";
    if (op == 7'h01) return (w[9:0] >= 10'd1 && w[9:0] <= 10'd15) ? "R2" : "R10";
    if (op >= 7'h08 && op <= 7'h11) return "R3";
    if (op == 7'h12) return "R4";
    if (op >= 7'h18 && op <= 7'h1C) return "R5";
    if ((op >= 7'h20 && op <= 7'h25) || (op >= 7'h30 && op <= 7'h32)) return "R6";
    if (op == 7'h40 || op == 7'h41) return "R7";
    if (op >= 7'h42 && op <= 7'h44) return "R8";
    return "R10";
  endfunction

  task automatic checkWord(input logic [31:0] w, input string tag);
    dec_t got, exp;
    @(negedge clk);
    instrWord = w;
    #2;
    exp = expectOf(w);
    got = '{rd: rdIdx, rs1: rs1Idx, rs2: rs2Idx, funct: functCode, imm: immValue,
            alu: aluOp, srcB: srcBImm, regWr: regWrEn, memRd: memRead, memWr: memWrite,
            memB: memByte, ldSgn: loadSigned, br: branchKind, push: pushOp, pop: popOp,
            srTo: srToReg, toSr: regToSr, halt: haltReq, ill: illegalInstr};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] rd,
                                     input logic [19:0] rest);
    return {op, rd, rest};
  endfunction

  localparam int NVALID = 31;
  localparam logic [6:0] VALID_OPS [NVALID] = '{
    7'h01, 7'h08, 7'h09, 7'h0A, 7'h0B, 7'h0C, 7'h0D, 7'h0E, 7'h0F, 7'h10, 7'h11,
    7'h12, 7'h18, 7'h19, 7'h1A, 7'h1B, 7'h1C, 7'h20, 7'h21, 7'h22, 7'h23, 7'h24,
    7'h25, 7'h30, 7'h31, 7'h32, 7'h40, 7'h41, 7'h42, 7'h43, 7'h44};

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20260515);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero word is illegal and quiet (R10)
    checkWord(32'h0000_0000, "R10");
    // R1: field positions on a register-register word
    checkWord(mk(7'h01, 5'd7, {5'd19, 5'd28, 10'h003}), "R1");
    // R2: every valid selector, and the out-of-range ones (R10)
    for (int f = 0; f < 20; f++)
      checkWord(mk(7'h01, 5'd3, {5'd4, 5'd5, 10'(f)}), (f >= 1 && f <= 15) ? "R2" : "R10");
    checkWord(mk(7'h01, 5'd3, {5'd4, 5'd5, 10'h3FF}), "R10");
    // R3: sign bit of the short constant
    checkWord(mk(7'h08, 5'd9, {5'd1, 15'h4000}), "R3");
    checkWord(mk(7'h08, 5'd9, {5'd1, 15'h3FFF}), "R3");
    checkWord(mk(7'h11, 5'd9, {5'd1, 15'h7FFF}), "R3");
    // R4: upper constant
    checkWord(mk(7'h12, 5'd10, 20'hFFFFF), "R4");
    checkWord(mk(7'h12, 5'd10, 20'h80001), "R4");
    // R5: loads and stores, store data index from [24:20]
    checkWord(mk(7'h1A, 5'd11, {5'd2, 15'h7FFC}), "R5");
    checkWord(mk(7'h19, 5'd12, {5'd2, 5'd30, 10'h004}), "R5");
    checkWord(mk(7'h1C, 5'd0,  {5'd2, 15'h0001}), "R5");
    // R6: jumps and branches with negative and positive offsets
    checkWord(mk(7'h30, 5'd0, 20'h80000), "R6");
    checkWord(mk(7'h31, 5'd1, 20'hFFFFC), "R6");
    checkWord(mk(7'h25, 5'd0, 20'h7FFFF), "R6");
    checkWord(mk(7'h32, 5'd0, {5'd1, 15'h1234}), "R6");
    // R7: stack
    checkWord(mk(7'h40, 5'd0, {5'd6, 15'h0000}), "R7");
    checkWord(mk(7'h41, 5'd6, 20'h00000), "R7");
    // R8: status moves and halt
    checkWord(mk(7'h42, 5'd8, 20'h00000), "R8");
    checkWord(mk(7'h43, 5'd0, {5'd8, 15'h0000}), "R8");
    checkWord(mk(7'h44, 5'd0, 20'h00000), "R8");
    // R9: zero destination with writing opcodes
    checkWord(mk(7'h01, 5'd0, {5'd4, 5'd5, 10'h001}), "R9");
    checkWord(mk(7'h41, 5'd0, 20'h00000), "R9");
    checkWord(mk(7'h31, 5'd0, 20'h00010), "R9");
    // R10: neighbours of each opcode group
    checkWord(mk(7'h13, 5'd3, 20'h12345), "R10");
    checkWord(mk(7'h1D, 5'd3, 20'h12345), "R10");
    checkWord(mk(7'h26, 5'd3, 20'h12345), "R10");
    checkWord(mk(7'h45, 5'd3, 20'h12345), "R10");
    checkWord(mk(7'h7F, 5'd3, 20'hFFFFF), "R10");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ((i % 4) != 0) begin
        w[31:25] = VALID_OPS[$urandom % NVALID];
        if (w[31:25] == 7'h01) w[9:0] = 10'($urandom % 20);
        if ((i % 16) == 1) w[24:20] = 5'd0;
      end
      checkWord(w, reqOf(w));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule